// File: doc/BRIEF.md
# Core Processing-State Controller

This block is the sequencer that decides which of six processing states a processor core occupies: normal, reset, exception, wait, stop or debug. It watches the asynchronous reset, a debug-active level, debug request and release strobes, the wait and stop instruction strobes, a pending-interrupt flag with its vector index, and an external wakeup. From these it drives the enables that the surrounding chip uses:

- a core clock enable
- an interrupt-logic enable
- an enable for peripherals that are allowed to stop
- an emulation-module enable

It also drives a one-cycle strobe that starts the first instruction fetch, and the fetch address of the service routine that an exception jumps to.

The state is held in one register. The next state is computed by a priority network. The enables and the vector address are decoded from the registered state, so every output changes on the clock edge after the input that causes it. Reset is the only exception to this: it acts at once.

Top module: `pstate_ctrl`

## Requirements
- R1: The 3-bit state code is always one of normal=0, reset=1, exception=2, wait=3, stop=4, debug=5. While reset is held, the code is 1, all four enables are low, the fetch strobe is low and the vector address is zero.
- R2: Driving `rst_n` low forces state code 1 at once, without waiting for a clock edge, whatever state the block was in.
- R3: At the first rising edge after `rst_n` goes high, the block moves to debug if `dbg_active` is high and to normal otherwise.
- R4: `first_fetch` is high for exactly the one cycle that follows the edge leaving reset, and is low at all other times.
- R5: In normal, the inputs are taken in this priority order: `dbg_req` enters debug, then `irq_pend` enters exception, then `stop_stb` enters stop, then `wait_stb` enters wait. With none of them, the block stays in normal.
- R6: In wait, `dbg_req` enters debug, otherwise `irq_pend` enters exception, otherwise the block stays. Exception lasts one cycle and then goes to normal, unless `dbg_req` is high, in which case it goes to debug.
- R7: On entry to exception, the vector address VEC_BASE + 2 × `irq_vec` (default base 0x0080) is captured. `vec_addr` shows it while in exception and is zero in every other state.
- R8: Stop is left only through `wake`, which goes to normal. In stop, `irq_pend`, `dbg_req`, `wait_stb` and `dbg_rel` have no effect.
- R9: Debug is left only through `dbg_rel`, which goes to normal. In debug, `irq_pend` and the other strobes have no effect.
- R10: The enables as (core, irq, periph, emu) are:

  | State | core | irq | periph | emu |
  |---|---|---|---|---|
  | normal | 1 | 1 | 1 | 0 |
  | exception | 1 | 1 | 1 | 0 |
  | wait | 0 | 1 | 1 | 0 |
  | stop | 0 | 0 | 0 | 0 |
  | debug | 0 | 1 | 1 | 1 |
  | reset | 0 | 0 | 0 | 0 |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dbg_active | input | 1 | Debug is active; chooses the state entered when reset is released |
| dbg_req | input | 1 | Debug request strobe |
| dbg_rel | input | 1 | Debug release strobe |
| wait_stb | input | 1 | Wait instruction strobe |
| stop_stb | input | 1 | Stop instruction strobe |
| irq_pend | input | 1 | An interrupt is pending |
| irq_vec | input | VEC_W | Vector index of the pending interrupt |
| wake | input | 1 | External wakeup out of stop |
| state_o | output | 3 | Current state code |
| core_clk_en | output | 1 | Core clock enable |
| irq_logic_en | output | 1 | Interrupt logic enable |
| periph_en | output | 1 | Enable for the peripherals that may be stopped |
| first_fetch | output | 1 | One-cycle strobe that starts the first fetch |
| vec_addr | output | ADDR_W | Fetch address of the service routine |
| emu_en | output | 1 | Emulation module enable |

## Verification
The input patterns fall into three groups.

- Single strobes in each state show that every transition goes to the right place.
- Several inputs raised together in normal, wait and exception show the priority order. For example, an interrupt together with stop and wait must give exception, and a debug request together with an interrupt must give debug.
- Strobes applied in stop and debug must leave the state unchanged, which separates the states that can be left only one way from the others.

Reset is applied in the middle of a clock cycle from different states and with both values of debug-active. This tells an immediate reset apart from a clocked one, and shows that the state after reset depends on debug-active. The vector address is tried with a small index and with the largest index, so that a missing doubling or a missing base shows up.

// File: rtl/pstate_pkg.sv
package pstate_pkg;

  typedef enum logic [2:0] {
    PS_NORM = 3'd0,
    PS_RST  = 3'd1,
    PS_EXC  = 3'd2,
    PS_WAIT = 3'd3,
    PS_STOP = 3'd4,
    PS_DBG  = 3'd5
  } pstate_e;

  typedef struct packed {
    logic core;
    logic irq;
    logic periph;
    logic emu;
  } pgate_t;

  function automatic pgate_t gates_of(input pstate_e s);
    pgate_t g;
    case (s)
      PS_NORM, PS_EXC: g = '{core: 1'b1, irq: 1'b1, periph: 1'b1, emu: 1'b0};
      PS_WAIT:         g = '{core: 1'b0, irq: 1'b1, periph: 1'b1, emu: 1'b0};
      PS_DBG:          g = '{core: 1'b0, irq: 1'b1, periph: 1'b1, emu: 1'b1};
      default:         g = '0;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/pstate_next.sv
module pstate_next
  import pstate_pkg::*;
(
  input  pstate_e cur,
  input  logic    dbg_active,
  input  logic    dbg_req,
  input  logic    dbg_rel,
  input  logic    wait_stb,
  input  logic    stop_stb,
  input  logic    irq_pend,
  input  logic    wake,
  output pstate_e nxt,
  output logic    enter_exc
);

  always_comb begin
    nxt = cur;
    case (cur)
      PS_RST: nxt = dbg_active ? PS_DBG : PS_NORM;
      PS_NORM: begin
        if (dbg_req)       nxt = PS_DBG;
        else if (irq_pend) nxt = PS_EXC;
        else if (stop_stb) nxt = PS_STOP;
        else if (wait_stb) nxt = PS_WAIT;
      end
      PS_WAIT: begin
        if (dbg_req)       nxt = PS_DBG;
        else if (irq_pend) nxt = PS_EXC;
      end
      PS_EXC:  nxt = dbg_req ? PS_DBG : PS_NORM;
      PS_STOP: if (wake) nxt = PS_NORM;
      PS_DBG:  if (dbg_rel) nxt = PS_NORM;
      default: nxt = PS_RST;
    endcase
  end

  assign enter_exc = (nxt == PS_EXC) && (cur != PS_EXC);

endmodule

// File: rtl/pstate_outdec.sv
module pstate_outdec
  import pstate_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  pstate_e           cur,
  input  logic [ADDR_W-1:0] vec_q,
  output logic              core_clk_en,
  output logic              irq_logic_en,
  output logic              periph_en,
  output logic              emu_en,
  output logic [ADDR_W-1:0] vec_addr
);

  pgate_t g;

  always_comb g = gates_of(cur);

  assign core_clk_en  = g.core;
  assign irq_logic_en = g.irq;
  assign periph_en    = g.periph;
  assign emu_en       = g.emu;
  assign vec_addr     = (cur == PS_EXC) ? vec_q : '0;

endmodule

// File: rtl/pstate_ctrl.sv
module pstate_ctrl
  import pstate_pkg::*;
#(
  parameter int                VEC_W    = 6,
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'h0080
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_active,
  input  logic              dbg_req,
  input  logic              dbg_rel,
  input  logic              wait_stb,
  input  logic              stop_stb,
  input  logic              irq_pend,
  input  logic [VEC_W-1:0]  irq_vec,
  input  logic              wake,
  output logic [2:0]        state_o,
  output logic              core_clk_en,
  output logic              irq_logic_en,
  output logic              periph_en,
  output logic              first_fetch,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              emu_en
);

  function automatic logic [ADDR_W-1:0] vec_of(input logic [VEC_W-1:0] idx);
    return VEC_BASE + (ADDR_W'(idx) << 1);
  endfunction

  pstate_e           state_q;
  pstate_e           nxt_state;
  logic              enter_exc;
  logic              leave_reset;
  logic              ff_q;
  logic [ADDR_W-1:0] vec_q;

  pstate_next u_next (
    .cur        (state_q),
    .dbg_active (dbg_active),
    .dbg_req    (dbg_req),
    .dbg_rel    (dbg_rel),
    .wait_stb   (wait_stb),
    .stop_stb   (stop_stb),
    .irq_pend   (irq_pend),
    .wake       (wake),
    .nxt        (nxt_state),
    .enter_exc  (enter_exc)
  );

  assign leave_reset = (state_q == PS_RST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_RST;
      ff_q    <= 1'b0;
      vec_q   <= '0;
    end else begin
      state_q <= nxt_state;
      ff_q    <= leave_reset;
      if (enter_exc) vec_q <= vec_of(irq_vec);
    end
  end

  pstate_outdec #(.ADDR_W(ADDR_W)) u_dec (
    .cur          (state_q),
    .vec_q        (vec_q),
    .core_clk_en  (core_clk_en),
    .irq_logic_en (irq_logic_en),
    .periph_en    (periph_en),
    .emu_en       (emu_en),
    .vec_addr     (vec_addr)
  );

  assign state_o     = state_q;
  assign first_fetch = ff_q;

endmodule

// File: rtl/pstate_ctrl_chk.sv
module pstate_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        state_o,
  input logic              core_clk_en,
  input logic              irq_logic_en,
  input logic              periph_en,
  input logic              emu_en,
  input logic              first_fetch,
  input logic [ADDR_W-1:0] vec_addr,
  input logic              wake,
  input logic              dbg_rel
);

  always_comb begin
    if (rst_n) AST_LEGAL_CODE: assert (state_o <= 3'd5); // R1
  end

  AST_FETCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    first_fetch |=> !first_fetch); // R4

  AST_FETCH_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    first_fetch |-> $past(state_o) == 3'd1); // R4

  AST_EXC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 3'd2 |=> state_o != 3'd2); // R6

  AST_VEC_ZERO_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 3'd2 |-> vec_addr == '0); // R7

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd4 && !wake) |=> state_o == 3'd4); // R8

  AST_DBG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd5 && !dbg_rel) |=> state_o == 3'd5); // R9

  AST_STOP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 3'd4 |-> !core_clk_en && !irq_logic_en && !periph_en); // R10

  AST_EMU_ONLY_DBG: assert property (@(posedge clk) disable iff (!rst_n)
    emu_en |-> state_o == 3'd5 && !core_clk_en); // R10

endmodule

bind pstate_ctrl pstate_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .state_o      (state_o),
  .core_clk_en  (core_clk_en),
  .irq_logic_en (irq_logic_en),
  .periph_en    (periph_en),
  .emu_en       (emu_en),
  .first_fetch  (first_fetch),
  .vec_addr     (vec_addr),
  .wake         (wake),
  .dbg_rel      (dbg_rel)
);

// File: tb/pstate_ctrl_bench.sv
`timescale 1ns/1ps
module pstate_ctrl_bench;

  localparam int VW = 6;
  localparam int AW = 16;
  localparam logic [AW-1:0] BASE = 16'h0080;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dbg_active = 1'b0, dbg_req = 1'b0, dbg_rel = 1'b0;
  logic wait_stb = 1'b0, stop_stb = 1'b0, irq_pend = 1'b0, wake = 1'b0;
  logic [VW-1:0] irq_vec = '0;
  logic [2:0] state_o;
  logic core_clk_en, irq_logic_en, periph_en, first_fetch, emu_en;
  logic [AW-1:0] vec_addr;

  always #2.5 clk = ~clk;

  pstate_ctrl #(.VEC_W(VW), .ADDR_W(AW), .VEC_BASE(BASE)) u_pstate_ctrl (
    .clk(clk), .rst_n(rst_n), .dbg_active(dbg_active), .dbg_req(dbg_req),
    .dbg_rel(dbg_rel), .wait_stb(wait_stb), .stop_stb(stop_stb),
    .irq_pend(irq_pend), .irq_vec(irq_vec), .wake(wake), .state_o(state_o),
    .core_clk_en(core_clk_en), .irq_logic_en(irq_logic_en),
    .periph_en(periph_en), .first_fetch(first_fetch), .vec_addr(vec_addr),
    .emu_en(emu_en)
  );

  typedef struct {
    logic [2:0]    st;
    logic [3:0]    gates;
    logic          ff;
    logic [AW-1:0] va;
    string         tag;
  } exp_t;

  exp_t    q[$];
  int      checks = 0;
  int      errors = 0;
  bit      done = 1'b0;
  int      m_st = 1;
  logic [AW-1:0] m_vec = '0;

  function automatic logic [3:0] gates_exp(input int s);
    case (s)
      0, 2:    return 4'b1110;
      3:       return 4'b0110;
      5:       return 4'b0111;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic int model_next(input int s);
    case (s)
      1: return dbg_active ? 5 : 0;
      0: if (dbg_req) return 5; else if (irq_pend) return 2;
         else if (stop_stb) return 4; else if (wait_stb) return 3; else return 0;
      3: if (dbg_req) return 5; else if (irq_pend) return 2; else return 3;
      2: return dbg_req ? 5 : 0;
      4: return wake ? 0 : 4;
      5: return dbg_rel ? 0 : 5;
      default: return 1;
    endcase
  endfunction

  task automatic push_exp(input string tag);
    exp_t e;
    int   n;
    n = model_next(m_st);
    if (n == 2 && m_st != 2) m_vec = BASE + {irq_vec, 1'b0};
    e.ff    = (m_st == 1);
    e.st    = n[2:0];
    e.gates = gates_exp(n);
    e.va    = (n == 2) ? m_vec : '0;
    e.tag   = tag;
    m_st    = n;
    q.push_back(e);
  endtask

  task automatic step(input logic dr, input logic rl, input logic wt,
                      input logic sp, input logic ir, input logic wk,
                      input logic [VW-1:0] idx, input string tag);
    @(negedge clk);
    dbg_req = dr; dbg_rel = rl; wait_stb = wt; stop_stb = sp;
    irq_pend = ir; wake = wk; irq_vec = idx;
    push_exp(tag);
  endtask

  task automatic do_reset(input logic dbg, input string tag);
    @(negedge clk);
    #0.5;
    rst_n = 1'b0;
    dbg_req = 0; dbg_rel = 0; wait_stb = 0; stop_stb = 0;
    irq_pend = 0; wake = 0; irq_vec = '0;
    dbg_active = dbg;
    #0.5;
    checks++;
    if (state_o !== 3'd1 || {core_clk_en, irq_logic_en, periph_en, emu_en} !== 4'b0000
        || first_fetch !== 1'b0 || vec_addr !== '0) begin
      errors++;
      $display("FAIL %s: immediate reset state=%0d gates=%b ff=%b va=%h expected state=1 gates=0000 ff=0 va=0",
               tag, state_o, {core_clk_en, irq_logic_en, periph_en, emu_en}, first_fetch, vec_addr);
    end
    m_st = 1;
    m_vec = '0;
    @(negedge clk);
    rst_n = 1'b1;
    push_exp({tag, " R3 R4 leave reset"});
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      logic [3:0] g;
      e = q.pop_front();
      g = {core_clk_en, irq_logic_en, periph_en, emu_en};
      checks++;
      if (state_o !== e.st || g !== e.gates || first_fetch !== e.ff || vec_addr !== e.va) begin
        errors++;
        $display("FAIL %s: state=%0d gates=%b ff=%b va=%h expected state=%0d gates=%b ff=%b va=%h",
                 e.tag, state_o, g, first_fetch, vec_addr, e.st, e.gates, e.ff, e.va);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (state_o !== 3'd1 || {core_clk_en, irq_logic_en, periph_en, emu_en} !== 4'b0000) begin
      errors++;
      $display("FAIL R1: reset hold state=%0d expected 1", state_o);
    end
    @(negedge clk);
    rst_n = 1'b1;
    push_exp("R3 R4 first release to normal");
    step(0,0,0,0,0,0,0, "R4 strobe drops");
    step(0,0,1,0,0,0,0, "R5 wait strobe, R10 wait gates");
    step(0,0,0,0,0,0,0, "R6 wait holds");
    step(0,0,0,0,1,0,6'd5, "R6 R7 irq in wait to exception");
    step(0,0,0,0,0,0,0, "R6 exception to normal");
    step(0,0,1,1,1,0,6'd1, "R5 irq beats stop and wait");
    step(0,0,0,0,0,0,0, "R6 back to normal");
    step(0,0,1,1,0,0,0, "R5 stop beats wait, R10 stop gates");
    step(1,1,1,0,1,0,6'd3, "R8 strobes ignored in stop");
    step(0,0,0,0,0,0,0, "R8 stop holds");
    step(0,0,0,0,0,1,0, "R8 wake to normal");
    step(1,0,1,1,1,0,6'd2, "R5 debug beats irq, R10 debug gates");
    step(0,0,1,1,1,1,6'd2, "R9 strobes ignored in debug");
    step(0,1,0,0,0,0,0, "R9 release to normal");
    step(0,0,1,0,0,0,0, "R5 enter wait");
    step(1,0,0,0,1,0,6'd4, "R6 debug beats irq in wait");
    step(0,1,0,0,0,0,0, "R9 release");
    step(0,0,0,0,1,0,6'd63, "R7 largest vector");
    step(1,0,0,0,0,0,0, "R6 debug from exception");
    step(0,1,0,0,0,0,0, "R9 release");
    step(0,0,0,1,0,0,0, "R5 enter stop");
    do_reset(1'b1, "R2 reset from stop with debug active");
    step(0,0,0,0,0,0,0, "R4 strobe drops in debug");
    step(0,1,0,0,0,0,0, "R9 release after reset");
    step(0,0,1,0,0,0,0, "R5 enter wait");
    do_reset(1'b0, "R2 reset from wait");
    step(0,0,0,0,1,0,6'd0, "R7 vector zero index");
    step(0,0,0,0,0,0,0, "R6 back to normal");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule